// File: doc/BRIEF.md
# Debug Module Run Control

This block is the run-control and abstract-command portion of a debug module serving a single hart. An external debugger reaches it through a slave port carrying a 7-bit register address and 32-bit data. The block keeps a control register, a status register, an abstract command status register, a command register and two 32-bit data words. Its outputs ask the hart to halt, reset the hart, or reset the rest of the system. It reads back the hart's halted, running and resume-acknowledge indications.

A debugger resets the system with a halt request held set. It releases the system reset and keeps the halt request, so the hart comes out of reset stopped. The hart-reset bit reads back as zero when hart reset is not built in, and software then falls back to the full-system reset. Register-access commands move a 64-bit value between the two data words and a simple core-side register port, with a request/acknowledge handshake.

Read responses come back one cycle after the request on a registered data output. Writes produce no response.

Top module: `dbg_runctl`

## Requirements
- R1: A read request returns its data on `dmi_rsp_rdata` with `dmi_rsp_valid` high in the following cycle. A write produces no response. A read of an address that maps to no register returns 0.
- R2: While the active bit (control bit 0) is 0, every read returns 0 and the three hart outputs are low. Writes to any register other than control are ignored. Clearing the active bit also clears the data words and the command state.
- R3: Control register (address 0x10) bit 31 drives `hart_halt_req`, bit 1 drives `sys_reset` and bit 0 is the active bit. All three read back as written.
- R4: With `HART_RESET_IMPL` = 0, control bit 29 reads back as 0 when written with 1, and `hart_reset` stays low.
- R5: The status register (address 0x11) reads version 2 in bits 3:0 and a fixed 1 in bit 7. Bits 9/8 reflect hart halted. Bits 11/10 reflect hart running and not halted. Bits 17/16 reflect resume acknowledge. A running hart reads 0x00030C82 and a halted one reads 0x00030382.
- R6: Writing 0x80000001 after 0x80000003 releases `sys_reset` and keeps `hart_halt_req` high. A later write of 0x00000001 clears the halt request.
- R7: The abstract status register (address 0x16) reads 0x10000002 when idle: program buffer size 16 in bits 28:24 and data count 2 in bits 3:0. Bit 12 (busy) is 1 while a command runs.
- R8: A write to the command register (0x17) starts a register access. The fields are: command type in bits 31:24 (must be 0), size in bits 22:20 (must be 3, 64-bit), transfer in bit 17, write in bit 16, and register number in bits 15:0. A read transfer stores the core's 64-bit value with the low half in data0 (0x04) and the high half in data1 (0x05).
- R9: A write transfer (bit 16 = 1) presents {data1, data0} on `reg_wdata` with `reg_we` high. The data words stay unchanged.
- R10: A command written while busy sets the error field (bits 10:8) to 1 and does not start a second access.
- R11: A register number of 0x1000 + `GPR_COUNT` or above, a size other than 3, or a nonzero command type sets the error field to 2 with no core access. Numbers 0x0000 to 0x0FFF (control/status registers) and 0x1000 + n for n < `GPR_COUNT` (general registers) are accepted.
- R12: Writing ones to bits 10:8 of the abstract status register clears the matching error bits. While the error field is nonzero, command writes are ignored.
- R13: `reg_req` stays high with a stable `reg_num` until `reg_ack` is seen. It falls in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmi_req_valid | input | 1 | Register access request |
| dmi_req_write | input | 1 | 1 = write, 0 = read |
| dmi_req_addr | input | 7 | Register address |
| dmi_req_wdata | input | 32 | Write data |
| dmi_rsp_valid | output | 1 | Read data valid |
| dmi_rsp_rdata | output | 32 | Read data |
| hart_halt_req | output | 1 | Halt request to the hart |
| hart_reset | output | 1 | Hart-only reset |
| sys_reset | output | 1 | Reset of everything but the debug module |
| hart_halted | input | 1 | Hart is halted |
| hart_running | input | 1 | Hart is running |
| hart_resume_ack | input | 1 | Hart acknowledged its last resume |
| reg_req | output | 1 | Core register access request |
| reg_we | output | 1 | 1 = write register, 0 = read |
| reg_num | output | 16 | Register number |
| reg_wdata | output | 64 | Value to write |
| reg_ack | input | 1 | Core finished the access |
| reg_rdata | input | 64 | Value read, valid with reg_ack |

## Verification
The hardest case to reach is a second command that lands while a register access is still waiting on the core. The bench's core model holds off its acknowledge for three cycles. The second command write is issued two cycles after the first, so it falls inside that window. The bench then confirms that only one access reached the core and that the error field reads 1. The reset-with-halt sequence needs the hart's reaction as well. A small hart model in the bench drops out of halted/running under system reset and halts as soon as it sees a halt request outside reset. The status reads taken before, during and after the system reset show that the halt request held through reset.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;
  localparam logic [6:0] ADR_DATA0 = 7'h04;
  localparam logic [6:0] ADR_DATA1 = 7'h05;
  localparam logic [6:0] ADR_CTRL  = 7'h10;
  localparam logic [6:0] ADR_STAT  = 7'h11;
  localparam logic [6:0] ADR_ACS   = 7'h16;
  localparam logic [6:0] ADR_CMD   = 7'h17;

  localparam logic [2:0] CERR_NONE  = 3'd0;
  localparam logic [2:0] CERR_BUSY  = 3'd1;
  localparam logic [2:0] CERR_UNSUP = 3'd2;

  localparam logic [3:0] STAT_VERSION = 4'd2;

  typedef struct packed {
    logic halt;
    logic hreset;
    logic sreset;
    logic active;
  } ctrl_t;
endpackage

// File: rtl/dbg_rc_ctrl.sv
module dbg_rc_ctrl
  import dbg_rc_pkg::*;
#(
  parameter bit HART_RESET_IMPL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_halt,
  input  logic        wr_hreset,
  input  logic        wr_sreset,
  input  logic        wr_active,
  input  logic        hart_halted,
  input  logic        hart_running,
  input  logic        hart_resume_ack,
  output ctrl_t       ctrl_q,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] stat_rdata
);
  logic hreset_in;
  logic run_only;

  generate
    if (HART_RESET_IMPL) begin : g_hreset
      assign hreset_in = wr_hreset;
    end else begin : g_no_hreset
      assign hreset_in = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (!wr_active) begin
        ctrl_q <= '0;
      end else begin
        ctrl_q.halt   <= wr_halt;
        ctrl_q.hreset <= hreset_in;
        ctrl_q.sreset <= wr_sreset;
        ctrl_q.active <= 1'b1;
      end
    end
  end

  assign run_only   = hart_running & ~hart_halted;
  assign ctrl_rdata = {ctrl_q.halt, 1'b0, ctrl_q.hreset, 27'd0, ctrl_q.sreset, ctrl_q.active};
  assign stat_rdata = {14'd0, hart_resume_ack, hart_resume_ack, 4'd0,
                       run_only, run_only, hart_halted, hart_halted,
                       1'b1, 3'd0, STAT_VERSION};
endmodule

// File: rtl/dbg_rc_abs.sv
module dbg_rc_abs
  import dbg_rc_pkg::*;
#(
  parameter int GPR_COUNT    = 32,
  parameter int PROGBUF_SIZE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [6:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] data0_rdata,
  output logic [31:0] data1_rdata,
  output logic [31:0] acs_rdata,
  output logic        reg_req,
  output logic        reg_we,
  output logic [15:0] reg_num,
  output logic [63:0] reg_wdata,
  input  logic        reg_ack,
  input  logic [63:0] reg_rdata
);
  localparam int          DATA_COUNT = 2;
  localparam int unsigned REG_LIMIT  = 32'h1000 + GPR_COUNT;
  localparam logic [4:0]  PB_FIELD   = 5'(PROGBUF_SIZE);
  localparam logic [3:0]  DC_FIELD   = 4'(DATA_COUNT);

  logic [31:0] data_q [DATA_COUNT];
  logic        busy_q;
  logic [2:0]  cerr_q;
  logic        cmd_ok;
  logic        reg_ok;

  assign reg_ok = {16'd0, wr_data[15:0]} < REG_LIMIT;
  assign cmd_ok = (wr_data[31:24] == 8'd0) && (wr_data[22:20] == 3'd3) && reg_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cerr_q    <= CERR_NONE;
      reg_we    <= 1'b0;
      reg_num   <= '0;
      reg_wdata <= '0;
      for (int i = 0; i < DATA_COUNT; i++) data_q[i] <= '0;
    end else begin
      if (busy_q && reg_ack) begin
        busy_q <= 1'b0;
        if (!reg_we) begin
          data_q[0] <= reg_rdata[31:0];
          data_q[1] <= reg_rdata[63:32];
        end
      end
      if (wr_en) begin
        unique case (wr_addr)
          ADR_CMD: begin
            if (busy_q) begin
              if (cerr_q == CERR_NONE) cerr_q <= CERR_BUSY;
            end else if (cerr_q == CERR_NONE) begin
              if (!cmd_ok) begin
                cerr_q <= CERR_UNSUP;
              end else if (wr_data[17]) begin
                busy_q    <= 1'b1;
                reg_we    <= wr_data[16];
                reg_num   <= wr_data[15:0];
                reg_wdata <= {data_q[1], data_q[0]};
              end
            end
          end
          ADR_ACS:   cerr_q <= cerr_q & ~wr_data[10:8];
          ADR_DATA0: if (!busy_q) data_q[0] <= wr_data;
          ADR_DATA1: if (!busy_q) data_q[1] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign reg_req     = busy_q;
  assign data0_rdata = data_q[0];
  assign data1_rdata = data_q[1];
  assign acs_rdata   = {3'd0, PB_FIELD, 11'd0, busy_q, 1'b0, cerr_q, 4'd0, DC_FIELD};
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_rc_pkg::*;
#(
  parameter bit HART_RESET_IMPL = 1'b0,
  parameter int GPR_COUNT       = 32,
  parameter int PROGBUF_SIZE    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dmi_req_valid,
  input  logic        dmi_req_write,
  input  logic [6:0]  dmi_req_addr,
  input  logic [31:0] dmi_req_wdata,
  output logic        dmi_rsp_valid,
  output logic [31:0] dmi_rsp_rdata,
  output logic        hart_halt_req,
  output logic        hart_reset,
  output logic        sys_reset,
  input  logic        hart_halted,
  input  logic        hart_running,
  input  logic        hart_resume_ack,
  output logic        reg_req,
  output logic        reg_we,
  output logic [15:0] reg_num,
  output logic [63:0] reg_wdata,
  input  logic        reg_ack,
  input  logic [63:0] reg_rdata
);
  ctrl_t       ctrl_q;
  logic        dm_active;
  logic        ctrl_wr;
  logic        abs_rst;
  logic        abs_wr;
  logic        rd_req;
  logic [31:0] ctrl_rdata, stat_rdata, acs_rdata, d0_rdata, d1_rdata;
  logic [31:0] rd_mux;

  assign ctrl_wr = dmi_req_valid & dmi_req_write & (dmi_req_addr == ADR_CTRL);
  assign abs_wr  = dmi_req_valid & dmi_req_write & dm_active;
  assign rd_req  = dmi_req_valid & ~dmi_req_write;
  assign abs_rst = rst | ~dm_active;

  dbg_rc_ctrl #(.HART_RESET_IMPL(HART_RESET_IMPL)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr),
    .wr_halt(dmi_req_wdata[31]), .wr_hreset(dmi_req_wdata[29]),
    .wr_sreset(dmi_req_wdata[1]), .wr_active(dmi_req_wdata[0]),
    .hart_halted(hart_halted), .hart_running(hart_running),
    .hart_resume_ack(hart_resume_ack),
    .ctrl_q(ctrl_q), .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata)
  );

  dbg_rc_abs #(.GPR_COUNT(GPR_COUNT), .PROGBUF_SIZE(PROGBUF_SIZE)) u_abs (
    .clk(clk), .rst(abs_rst), .wr_en(abs_wr), .wr_addr(dmi_req_addr),
    .wr_data(dmi_req_wdata), .data0_rdata(d0_rdata), .data1_rdata(d1_rdata),
    .acs_rdata(acs_rdata), .reg_req(reg_req), .reg_we(reg_we),
    .reg_num(reg_num), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata)
  );

  assign dm_active     = ctrl_q.active;
  assign hart_halt_req = ctrl_q.halt;
  assign hart_reset    = ctrl_q.hreset;
  assign sys_reset     = ctrl_q.sreset;

  always_comb begin
    unique case (dmi_req_addr)
      ADR_CTRL:  rd_mux = ctrl_rdata;
      ADR_STAT:  rd_mux = stat_rdata;
      ADR_ACS:   rd_mux = acs_rdata;
      ADR_DATA0: rd_mux = d0_rdata;
      ADR_DATA1: rd_mux = d1_rdata;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmi_rsp_valid <= 1'b0;
      dmi_rsp_rdata <= '0;
    end else begin
      dmi_rsp_valid <= rd_req;
      if (rd_req) dmi_rsp_rdata <= dm_active ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
  import dbg_rc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        dmi_req_valid,
  input logic        dmi_req_write,
  input logic [6:0]  dmi_req_addr,
  input logic        wdata_active,
  input logic        dmi_rsp_valid,
  input logic [31:0] dmi_rsp_rdata,
  input logic        hart_halt_req,
  input logic        hart_reset,
  input logic        sys_reset,
  input logic        hart_halted,
  input logic        reg_req,
  input logic        reg_ack,
  input logic [15:0] reg_num,
  input logic        dm_active
);
  p_read_resp_r1: assert property (@(posedge clk) disable iff (rst)
    dmi_req_valid && !dmi_req_write |=> dmi_rsp_valid);

  p_deactivate_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    dmi_req_valid && dmi_req_write && dmi_req_addr == ADR_CTRL && !wdata_active
    |=> !hart_halt_req && !sys_reset && !hart_reset);

  p_ctrl_readback_r3: assert property (@(posedge clk) disable iff (rst)
    dmi_req_valid && !dmi_req_write && dmi_req_addr == ADR_CTRL
    |=> dmi_rsp_rdata[31] == hart_halt_req && dmi_rsp_rdata[1] == sys_reset
        && dmi_rsp_rdata[29] == hart_reset);

  p_status_halt_r5: assert property (@(posedge clk) disable iff (rst)
    dm_active && dmi_req_valid && !dmi_req_write && dmi_req_addr == ADR_STAT
    |=> dmi_rsp_rdata[9] == $past(hart_halted) && dmi_rsp_rdata[7]);

  p_req_origin_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_req) |-> $past(dmi_req_valid && dmi_req_write && dmi_req_addr == ADR_CMD));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req && $stable(reg_num));

  p_req_drop_r13: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_ack |=> !reg_req);
endmodule

bind dbg_runctl dbg_runctl_chk u_chk (
  .clk(clk), .rst(rst), .dmi_req_valid(dmi_req_valid),
  .dmi_req_write(dmi_req_write), .dmi_req_addr(dmi_req_addr),
  .wdata_active(dmi_req_wdata[0]), .dmi_rsp_valid(dmi_rsp_valid),
  .dmi_rsp_rdata(dmi_rsp_rdata), .hart_halt_req(hart_halt_req),
  .hart_reset(hart_reset), .sys_reset(sys_reset), .hart_halted(hart_halted),
  .reg_req(reg_req), .reg_ack(reg_ack), .reg_num(reg_num), .dm_active(dm_active)
);

// File: tb/tb_dbg_runctl.sv
`timescale 1ns/1ps
module tb_dbg_runctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        halt_req, hreset, sreset;
  logic        h_halted = 1'b0, h_running = 1'b1, h_rack = 1'b1;
  logic        reg_req, reg_we, reg_ack = 1'b0;
  logic [15:0] reg_num;
  logic [63:0] reg_wdata, reg_rdata = '0;

  int checks = 0, errors = 0;
  int acc_cnt = 0;
  logic [15:0] last_num = '0;
  logic        last_we = 1'b0;
  logic [63:0] last_wdata = '0;

  always #10 clk = ~clk;

  dbg_runctl dut (
    .clk(clk), .rst(rst), .dmi_req_valid(req_valid), .dmi_req_write(req_write),
    .dmi_req_addr(req_addr), .dmi_req_wdata(req_wdata), .dmi_rsp_valid(rsp_valid),
    .dmi_rsp_rdata(rsp_rdata), .hart_halt_req(halt_req), .hart_reset(hreset),
    .sys_reset(sreset), .hart_halted(h_halted), .hart_running(h_running),
    .hart_resume_ack(h_rack), .reg_req(reg_req), .reg_we(reg_we), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  // Hart model: drops out under system reset, halts on request outside reset.
  always @(posedge clk) begin
    if (sreset) begin
      h_halted  <= 1'b0;
      h_running <= 1'b0;
    end else if (halt_req) begin
      h_halted  <= 1'b1;
      h_running <= 1'b0;
    end else if (!h_halted) begin
      h_running <= 1'b1;
    end
  end

  // Core register port model: acknowledge on the third negedge of a request.
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (reg_req && !reg_ack) begin
        wait_cnt++;
        if (wait_cnt == 3) begin
          reg_ack    = 1'b1;
          reg_rdata  = 64'h1122_3344_5566_7788;
          last_num   = reg_num;
          last_we    = reg_we;
          last_wdata = reg_wdata;
          acc_cnt++;
          wait_cnt   = 0;
        end
      end else begin
        reg_ack = 1'b0;
      end
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic dmi(input logic w, input logic [6:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic rv);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    rv = rsp_valid;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    dmi(1'b1, a, d, rd, rv);
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic rv;
    dmi(1'b0, a, 32'd0, rd, rv);
    chk({63'd0, rv}, 64'd1, tag);
    chk({32'd0, rd}, {32'd0, exp}, tag);
  endtask

  // {write, addr, wdata, expected read data}
  localparam int NV = 20;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 7'h10, 32'h0,        32'h0},        // R2 inactive read
    {1'b0, 7'h11, 32'h0,        32'h0},        // R2
    {1'b1, 7'h04, 32'hDEADBEEF, 32'h0},        // R2 ignored write
    {1'b1, 7'h10, 32'h00000001, 32'h0},        // R3 activate
    {1'b0, 7'h10, 32'h0,        32'h00000001}, // R3
    {1'b0, 7'h11, 32'h0,        32'h00030C82}, // R5 running
    {1'b0, 7'h04, 32'h0,        32'h0},        // R2 write was dropped
    {1'b0, 7'h16, 32'h0,        32'h10000002}, // R7 idle
    {1'b1, 7'h10, 32'hA0000001, 32'h0},        // R4 halt + hart reset
    {1'b0, 7'h10, 32'h0,        32'h80000001}, // R4 bit 29 reads 0
    {1'b0, 7'h11, 32'h0,        32'h00030382}, // R5 halted
    {1'b1, 7'h10, 32'h80000003, 32'h0},        // R6 system reset
    {1'b0, 7'h10, 32'h0,        32'h80000003}, // R3
    {1'b0, 7'h11, 32'h0,        32'h00030082}, // R6 hart held in reset
    {1'b1, 7'h10, 32'h80000001, 32'h0},        // R6 release, keep halt
    {1'b0, 7'h10, 32'h0,        32'h80000001}, // R6
    {1'b0, 7'h11, 32'h0,        32'h00030382}, // R6 left reset halted
    {1'b1, 7'h10, 32'h00000001, 32'h0},        // R6 clear halt request
    {1'b0, 7'h10, 32'h0,        32'h00000001}, // R6
    {1'b0, 7'h7F, 32'h0,        32'h0}         // R1 unmapped
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion (R1..R13 run)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({61'd0, halt_req, sreset, hreset}, 64'd0, "R2 reset outputs");
    chk({62'd0, rsp_valid, reg_req}, 64'd0, "R1 reset idle");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:64], VEC[i][63:32]);
      else rd_chk(VEC[i][70:64], VEC[i][31:0], $sformatf("vector %0d", i));
    end

    // R7 R10 R8 R13: read access, busy, collision
    wr(7'h17, 32'h00321008);
    rd_chk(7'h16, 32'h10001002, "R7 busy");
    wr(7'h17, 32'h00321008);
    repeat (4) @(negedge clk);
    rd_chk(7'h16, 32'h10000102, "R10 cmderr busy");
    chk(acc_cnt, 1, "R10 single access");
    rd_chk(7'h04, 32'h55667788, "R8 data0 low half");
    rd_chk(7'h05, 32'h11223344, "R8 data1 high half");
    chk({47'd0, last_we, last_num}, {47'd0, 1'b0, 16'h1008}, "R8 regno/dir");
    chk({63'd0, reg_req}, 64'd0, "R13 request dropped");
    wr(7'h16, 32'h00000700);
    rd_chk(7'h16, 32'h10000002, "R12 cleared");

    // R11 R12: unsupported commands and lockout
    wr(7'h17, 32'h00221008);
    rd_chk(7'h16, 32'h10000202, "R11 bad size");
    wr(7'h17, 32'h00321008);
    repeat (4) @(negedge clk);
    chk(acc_cnt, 1, "R12 ignored while error");
    rd_chk(7'h16, 32'h10000202, "R12 error kept");
    wr(7'h16, 32'h00000700);
    wr(7'h17, 32'h00321020);
    rd_chk(7'h16, 32'h10000202, "R11 bad regno");
    chk(acc_cnt, 1, "R11 no access");
    wr(7'h16, 32'h00000700);

    // R9: write transfer
    wr(7'h04, 32'hCAFEF00D);
    wr(7'h05, 32'h0BADBEEF);
    wr(7'h17, 32'h00331005);
    repeat (5) @(negedge clk);
    chk(acc_cnt, 2, "R9 access");
    chk({47'd0, last_we, last_num}, {47'd0, 1'b1, 16'h1005}, "R9 regno/dir");
    chk(last_wdata, 64'h0BADBEEF_CAFEF00D, "R9 wdata");
    rd_chk(7'h04, 32'hCAFEF00D, "R9 data0 kept");

    // R11: CSR number accepted
    wr(7'h17, 32'h003207B1);
    repeat (5) @(negedge clk);
    chk(acc_cnt, 3, "R11 csr access");
    chk({48'd0, last_num}, 64'h07B1, "R11 csr regno");
    rd_chk(7'h16, 32'h10000002, "R11 no error");

    // R2: deactivation clears everything
    wr(7'h10, 32'h80000003);
    wr(7'h10, 32'h00000000);
    chk({62'd0, halt_req, sreset}, 64'd0, "R2 outputs low");
    rd_chk(7'h16, 32'h0, "R2 reads zero");
    wr(7'h10, 32'h00000001);
    rd_chk(7'h04, 32'h0, "R2 data cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule